// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block decides which frequency setting a clock synthesizer runs from, and it flags every moment that setting changes. Three sources compete. The first is a 5-bit strap value, captured once from board pins. The second is a 5-bit software select with an override flag. The third is a programmable divider pair N/M, from which the synthesizer derives its frequency as G*(N+3)/(M+3). The select logic only chooses among these sources. The PLL and the arithmetic are outside the block.

A small register write port loads the configuration. A recovery input puts the block into a locked state. In that state the active setting comes from a recovery source, which is either the strap value or a separate recovery N/M pair. Frequency-affecting writes are refused until a release input clears the lock. Every change of the active setting raises a one-cycle strobe, so the synthesizer can start a relock.

All pins are plain control and status. The block has no stream interface and no back-pressure.

Top module: `clksrc_select`

## Requirements
- R1: The strap register captures `strap_pins` on the first rising clock edge after reset at which `pwrgd_n` is low. It never changes again until the next reset. Before the capture it reads 0. The capture does not raise `chg_strobe`.
- R2: With programmable mode off (control bit 6 = 0), `prog_mode` is 0 and `act_n`/`act_m` read 0. `act_index` is the strap value when override (control bit 5) is 0, and the select bits (control bits [4:0]) when override is 1.
- R3: With programmable mode on, `prog_mode` is 1 and `act_n`/`act_m` show the N and M registers. The override flag still picks the source of `act_index` exactly as in R2.
- R4: Every accepted write to N (address 1, bits [7:0]) or M (address 2, bits [6:0]) raises `chg_strobe` for one cycle. This holds even if the value is unchanged or programmable mode is off.
- R5: A write to the control register (address 0) raises `chg_strobe` only when it changes `act_index` or `prog_mode`.
- R6: A `rcv_enter` pulse while unlocked sets `rcv_locked` and loads the recovery setting at the same edge. It raises `chg_strobe` once. A further `rcv_enter` while locked does nothing.
- R7: The recovery setting depends on recovery-select (address 4, bit 7). When it is 1, `prog_mode` = 1, N/M come from the recovery pair (recovery N at address 3, recovery M at address 4 bits [6:0]), and the index follows override. When it is 0, the index is the strap value, `prog_mode` = 0 and N/M read 0.
- R8: While locked, writes to addresses 0 to 4 are dropped. This holds both for their outputs and for the stored registers.
- R9: A `rcv_release` pulse while locked clears the lock. The outputs then return to the normal configuration with one `chg_strobe`. A release while unlocked does nothing.
- R10: A write to N, M, recovery N or recovery M that would leave N not greater than M (M zero-extended) is rejected. The stored value is kept. `ratio_err` pulses for one cycle and no strobe is raised.
- R11: After reset, all configuration registers are 0 and the block is unlocked. The outputs read 0 and both pulses are low.
- R12: If `rcv_enter` and a write arrive in the same cycle, the lock wins and the write is dropped. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_n | input | 1 | Power-good, active low; gates the strap capture |
| strap_pins | input | 5 | Board strap value |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| rcv_enter | input | 1 | Enter the locked recovery state |
| rcv_release | input | 1 | Leave the recovery state |
| act_index | output | 5 | Active frequency index |
| act_n | output | 8 | Active N value (0 when not programmable) |
| act_m | output | 7 | Active M value (0 when not programmable) |
| prog_mode | output | 1 | Active setting uses the N/M divider |
| chg_strobe | output | 1 | One-cycle pulse on a frequency change |
| ratio_err | output | 1 | One-cycle pulse on a rejected N/M write |
| rcv_locked | output | 1 | Recovery lock is active |

## Verification
The bench tests the ratio boundary where N equals M, which must be refused. A design that compared with greater-or-equal would accept that write and strobe. It checks control writes that alter only bits the active index does not use, where a design strobing on every write would fire falsely. Writes attempted during the lock and in the same cycle as the lock request are examined after release. A design that merely masked the outputs would show the new N at that point. The bench also moves the strap pins after the capture and resets mid-run, which exposes a latch that is transparent or never re-armed.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  localparam int IDX_W  = 5;
  localparam int N_W    = 8;
  localparam int M_W    = 7;
  localparam int ADDR_W = 3;
  localparam int DATA_W = N_W;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_NVAL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MVAL  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RNVAL = 3'd3;
  localparam logic [ADDR_W-1:0] A_RMVAL = 3'd4;

  localparam int B_OVR  = 5;
  localparam int B_PROG = 6;
  localparam int B_RSEL = 7;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [N_W-1:0]   n;
    logic [M_W-1:0]   m;
    logic             prog;
  } setting_t;

  // divider pair is usable only when N strictly exceeds M
  function automatic logic ratio_ok(input logic [N_W-1:0] n, input logic [M_W-1:0] m);
    return n > N_W'(m);
  endfunction
endpackage

// File: rtl/clksrc_strap.sv
module clksrc_strap
  import clksrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrgd_n,
  input  logic [IDX_W-1:0] pins,
  output logic [IDX_W-1:0] value,
  output logic             latched
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value   <= '0;
      latched <= 1'b0;
    end else if (!latched && !pwrgd_n) begin
      value   <= pins;
      latched <= 1'b1;
    end
  end

  // R1: once captured, the strap value is frozen
  assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> (latched && $stable(value)));
  // R1: no capture while power-good is still high
  assert_strap_waits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!latched && pwrgd_n) |=> (!latched && $stable(value)));
endmodule

// File: rtl/clksrc_cfg.sv
module clksrc_cfg
  import clksrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              block,
  output logic [IDX_W-1:0]  sel_q,
  output logic              ovr_q,
  output logic              prog_q,
  output logic [N_W-1:0]    n_q,
  output logic [M_W-1:0]    m_q,
  output logic [N_W-1:0]    rn_q,
  output logic [M_W-1:0]    rm_q,
  output logic              rsel_q,
  output logic [IDX_W-1:0]  sel_d,
  output logic              ovr_d,
  output logic              prog_d,
  output logic [N_W-1:0]    n_d,
  output logic [M_W-1:0]    m_d,
  output logic [N_W-1:0]    rn_d,
  output logic [M_W-1:0]    rm_d,
  output logic              rsel_d,
  output logic              nm_applied,
  output logic              ratio_bad
);
  logic [M_W-1:0] wr_m;
  assign wr_m = wr_data[M_W-1:0];

  always_comb begin
    sel_d      = sel_q;
    ovr_d      = ovr_q;
    prog_d     = prog_q;
    n_d        = n_q;
    m_d        = m_q;
    rn_d       = rn_q;
    rm_d       = rm_q;
    rsel_d     = rsel_q;
    nm_applied = 1'b0;
    ratio_bad  = 1'b0;
    if (wr_en && !block) begin
      case (wr_addr)
        A_CTRL: begin
          sel_d  = wr_data[IDX_W-1:0];
          ovr_d  = wr_data[B_OVR];
          prog_d = wr_data[B_PROG];
        end
        A_NVAL: begin
          if (ratio_ok(wr_data, m_q)) begin
            n_d        = wr_data;
            nm_applied = 1'b1;
          end else begin
            ratio_bad = 1'b1;
          end
        end
        A_MVAL: begin
          if (ratio_ok(n_q, wr_m)) begin
            m_d        = wr_m;
            nm_applied = 1'b1;
          end else begin
            ratio_bad = 1'b1;
          end
        end
        A_RNVAL: begin
          if (ratio_ok(wr_data, rm_q)) rn_d = wr_data;
          else                         ratio_bad = 1'b1;
        end
        A_RMVAL: begin
          if (ratio_ok(rn_q, wr_m)) begin
            rm_d   = wr_m;
            rsel_d = wr_data[B_RSEL];
          end else begin
            ratio_bad = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      ovr_q  <= 1'b0;
      prog_q <= 1'b0;
      n_q    <= '0;
      m_q    <= '0;
      rn_q   <= '0;
      rm_q   <= '0;
      rsel_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      ovr_q  <= ovr_d;
      prog_q <= prog_d;
      n_q    <= n_d;
      m_q    <= m_d;
      rn_q   <= rn_d;
      rm_q   <= rm_d;
      rsel_q <= rsel_d;
    end
  end

  // R10: an N write not above the stored M leaves N untouched
  assert_ratio_keep_n_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !block && wr_addr == A_NVAL && wr_data <= N_W'(m_q)) |=> $stable(n_q));
  // R10: an M write not below the stored N leaves M untouched
  assert_ratio_keep_m_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !block && wr_addr == A_MVAL && n_q <= N_W'(wr_m)) |=> $stable(m_q));
  // R8: blocked writes change no stored register
  assert_block_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && block) |=> ($stable(n_q) && $stable(m_q) && $stable(sel_q) && $stable(ovr_q)
                          && $stable(prog_q) && $stable(rn_q) && $stable(rm_q) && $stable(rsel_q)));
endmodule

// File: rtl/clksrc_pick.sv
module clksrc_pick
  import clksrc_pkg::*;
(
  input  logic             locked,
  input  logic [IDX_W-1:0] strap,
  input  logic [IDX_W-1:0] sel,
  input  logic             ovr,
  input  logic             prog_en,
  input  logic [N_W-1:0]   n,
  input  logic [M_W-1:0]   m,
  input  logic             rsel,
  input  logic [N_W-1:0]   rn,
  input  logic [M_W-1:0]   rm,
  output setting_t         pick
);
  logic [IDX_W-1:0] ratio_idx;
  assign ratio_idx = ovr ? sel : strap;

  always_comb begin
    pick.idx  = ratio_idx;
    pick.n    = '0;
    pick.m    = '0;
    pick.prog = 1'b0;
    if (locked) begin
      if (rsel) begin
        pick.n    = rn;
        pick.m    = rm;
        pick.prog = 1'b1;
      end else begin
        pick.idx  = strap;
      end
    end else if (prog_en) begin
      pick.n    = n;
      pick.m    = m;
      pick.prog = 1'b1;
    end
  end
endmodule

// File: rtl/clksrc_select.sv
module clksrc_select
  import clksrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrgd_n,
  input  logic [IDX_W-1:0]  strap_pins,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rcv_enter,
  input  logic              rcv_release,
  output logic [IDX_W-1:0]  act_index,
  output logic [N_W-1:0]    act_n,
  output logic [M_W-1:0]    act_m,
  output logic              prog_mode,
  output logic              chg_strobe,
  output logic              ratio_err,
  output logic              rcv_locked
);
  logic [IDX_W-1:0] strap_val;
  logic             strap_latched;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic             ovr_q, ovr_d, prog_q, prog_d, rsel_q, rsel_d;
  logic [N_W-1:0]   n_q, n_d, rn_q, rn_d;
  logic [M_W-1:0]   m_q, m_d, rm_q, rm_d;
  logic             nm_applied, ratio_bad;
  logic             lock_q, lock_d, enter_go, release_go, block;
  logic             strobe_q, err_q;
  setting_t         cur, nxt;

  assign enter_go   = rcv_enter && !lock_q;
  assign release_go = rcv_release && lock_q && !rcv_enter;
  assign lock_d     = enter_go ? 1'b1 : (release_go ? 1'b0 : lock_q);
  assign block      = lock_q | rcv_enter;

  clksrc_strap u_strap (
    .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .pins(strap_pins),
    .value(strap_val), .latched(strap_latched)
  );

  clksrc_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .block(block),
    .sel_q(sel_q), .ovr_q(ovr_q), .prog_q(prog_q), .n_q(n_q), .m_q(m_q),
    .rn_q(rn_q), .rm_q(rm_q), .rsel_q(rsel_q),
    .sel_d(sel_d), .ovr_d(ovr_d), .prog_d(prog_d), .n_d(n_d), .m_d(m_d),
    .rn_d(rn_d), .rm_d(rm_d), .rsel_d(rsel_d),
    .nm_applied(nm_applied), .ratio_bad(ratio_bad)
  );

  // setting in force now
  clksrc_pick u_pick_cur (
    .locked(lock_q), .strap(strap_val), .sel(sel_q), .ovr(ovr_q), .prog_en(prog_q),
    .n(n_q), .m(m_q), .rsel(rsel_q), .rn(rn_q), .rm(rm_q), .pick(cur)
  );

  // setting after this edge, strap held so a capture does not strobe
  clksrc_pick u_pick_nxt (
    .locked(lock_d), .strap(strap_val), .sel(sel_d), .ovr(ovr_d), .prog_en(prog_d),
    .n(n_d), .m(m_d), .rsel(rsel_d), .rn(rn_d), .rm(rm_d), .pick(nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      strobe_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      lock_q   <= lock_d;
      strobe_q <= enter_go | release_go | nm_applied | (cur != nxt);
      err_q    <= ratio_bad;
    end
  end

  assign act_index  = cur.idx;
  assign act_n      = cur.n;
  assign act_m      = cur.m;
  assign prog_mode  = cur.prog;
  assign chg_strobe = strobe_q;
  assign ratio_err  = err_q;
  assign rcv_locked = lock_q;

  // R6: entering recovery locks and strobes at the next edge
  assert_enter_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_enter && !rcv_locked) |=> (rcv_locked && chg_strobe));
  // R9: a release while locked unlocks and strobes
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_release && rcv_locked && !rcv_enter) |=> (!rcv_locked && chg_strobe));
  // R8: outputs hold steady through the lock
  assert_lock_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_locked && !rcv_release && strap_latched) |=>
      ($stable(act_index) && $stable(act_n) && $stable(act_m) && $stable(prog_mode)));
  // R10: a rejected write never comes with a strobe
  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |-> !chg_strobe);
endmodule

// File: tb/sim_clksrc_select.sv
module sim_clksrc_select;
  logic       clk = 1'b0;
  logic       rst_n, pwrgd_n, wr_en, rcv_enter, rcv_release;
  logic [4:0] strap_pins;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [4:0] act_index;
  logic [7:0] act_n;
  logic [6:0] act_m;
  logic       prog_mode, chg_strobe, ratio_err, rcv_locked;
  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  clksrc_select u0 (
    .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .strap_pins(strap_pins),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rcv_enter(rcv_enter), .rcv_release(rcv_release),
    .act_index(act_index), .act_n(act_n), .act_m(act_m), .prog_mode(prog_mode),
    .chg_strobe(chg_strobe), .ratio_err(ratio_err), .rcv_locked(rcv_locked)
  );

  // {addr, data, idx, n, m, mode, strobe, err}
  localparam int NV = 15;
  localparam logic [33:0] VEC [NV] = '{
    {3'd0, 8'h09, 5'h16, 8'h00, 7'h00, 1'b0, 1'b0, 1'b0},  // R5 select unused
    {3'd0, 8'h29, 5'h09, 8'h00, 7'h00, 1'b0, 1'b1, 1'b0},  // R2 override
    {3'd2, 8'h05, 5'h09, 8'h00, 7'h00, 1'b0, 1'b0, 1'b1},  // R10 M over N
    {3'd1, 8'h60, 5'h09, 8'h00, 7'h00, 1'b0, 1'b1, 1'b0},  // R4 N, prog off
    {3'd2, 8'h5D, 5'h09, 8'h00, 7'h00, 1'b0, 1'b1, 1'b0},  // R4 M
    {3'd0, 8'h69, 5'h09, 8'h60, 7'h5D, 1'b1, 1'b1, 1'b0},  // R3 prog on
    {3'd1, 8'h5D, 5'h09, 8'h60, 7'h5D, 1'b1, 1'b0, 1'b1},  // R10 N == M
    {3'd1, 8'h5E, 5'h09, 8'h5E, 7'h5D, 1'b1, 1'b1, 1'b0},  // R10 N == M+1
    {3'd0, 8'h49, 5'h16, 8'h5E, 7'h5D, 1'b1, 1'b1, 1'b0},  // R3 strap index
    {3'd0, 8'h4A, 5'h16, 8'h5E, 7'h5D, 1'b1, 1'b0, 1'b0},  // R5 no change
    {3'd1, 8'h5E, 5'h16, 8'h5E, 7'h5D, 1'b1, 1'b1, 1'b0},  // R4 same value
    {3'd5, 8'hFF, 5'h16, 8'h5E, 7'h5D, 1'b1, 1'b0, 1'b0},  // R12 unmapped
    {3'd4, 8'h81, 5'h16, 8'h5E, 7'h5D, 1'b1, 1'b0, 1'b1},  // R10 recovery M
    {3'd3, 8'h80, 5'h16, 8'h5E, 7'h5D, 1'b1, 1'b0, 1'b0},  // R7 recovery N
    {3'd4, 8'h81, 5'h16, 8'h5E, 7'h5D, 1'b1, 1'b0, 1'b0}   // R7 recovery M
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int idx, input int n, input int m,
                         input int mode, input int stb, input int err);
    chk(req, "act_index", int'(act_index), idx);
    chk(req, "act_n", int'(act_n), n);
    chk(req, "act_m", int'(act_m), m);
    chk(req, "prog_mode", int'(prog_mode), mode);
    chk(req, "chg_strobe", int'(chg_strobe), stb);
    chk(req, "ratio_err", int'(ratio_err), err);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_enter();
    @(negedge clk); rcv_enter = 1'b1;
    @(negedge clk); rcv_enter = 1'b0;
  endtask

  task automatic pulse_release();
    @(negedge clk); rcv_release = 1'b1;
    @(negedge clk); rcv_release = 1'b0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwrgd_n = 1'b1; strap_pins = 5'h16;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rcv_enter = 1'b0; rcv_release = 1'b0;
    repeat (3) @(negedge clk);
    chk_out("R11", 0, 0, 0, 0, 0, 0);
    chk("R11", "rcv_locked", int'(rcv_locked), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pre-capture index", int'(act_index), 0);
    pwrgd_n = 1'b0;
    @(negedge clk);
    chk("R1", "captured index", int'(act_index), 'h16);
    chk("R1", "no strobe on capture", int'(chg_strobe), 0);
    strap_pins = 5'h03; pwrgd_n = 1'b1;
    @(negedge clk); pwrgd_n = 1'b0;
    @(negedge clk);
    chk("R1", "frozen index", int'(act_index), 'h16);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][33:31], VEC[i][30:23]);
      chk_out($sformatf("vec%0d", i), int'(VEC[i][22:18]), int'(VEC[i][17:10]),
              int'(VEC[i][9:3]), int'(VEC[i][2]), int'(VEC[i][1]), int'(VEC[i][0]));
    end

    // R6/R7 recovery from the N/M pair
    pulse_enter();
    chk_out("R6", 'h16, 'h80, 'h01, 1, 1, 0);
    chk("R6", "locked", int'(rcv_locked), 1);
    @(negedge clk);
    chk("R6", "strobe once", int'(chg_strobe), 0);
    pulse_enter();
    chk("R6", "re-enter quiet", int'(chg_strobe), 0);

    // R8 writes dropped while locked
    wr(3'd1, 8'h70);
    chk_out("R8", 'h16, 'h80, 'h01, 1, 0, 0);
    wr(3'd0, 8'h2A);
    chk("R8", "index held", int'(act_index), 'h16);
    wr(3'd4, 8'h02);
    chk("R8", "recovery n held", int'(act_n), 'h80);

    // R9 release restores the normal setting; stored N proves R8
    pulse_release();
    chk_out("R9", 'h16, 'h5E, 'h5D, 1, 1, 0);
    chk("R9", "unlocked", int'(rcv_locked), 0);
    pulse_release();
    chk("R9", "idle release quiet", int'(chg_strobe), 0);

    // R7 recovery from the strap value
    wr(3'd4, 8'h01);
    chk_out("R7", 'h16, 'h5E, 'h5D, 1, 0, 0);
    pulse_enter();
    chk_out("R7", 'h16, 0, 0, 0, 1, 0);
    pulse_release();

    // R12 lock request and write in the same cycle
    @(negedge clk);
    rcv_enter = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h71;
    @(negedge clk);
    rcv_enter = 1'b0; wr_en = 1'b0;
    chk("R12", "locked", int'(rcv_locked), 1);
    pulse_release();
    chk("R12", "write dropped", int'(act_n), 'h5E);

    // R11 reset mid-run, then R1 recapture of the new pins
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk_out("R11", 0, 0, 0, 0, 0, 0);
    chk("R11", "unlocked", int'(rcv_locked), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "recapture", int'(act_index), 'h03);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule